// File: doc/BRIEF.md
# Packet Timestamp Latch

This block holds the local clock time at which an event packet crossed the stamping point, one holding register per direction (transmit and receive). When a qualified event strobe arrives and the latch of that direction is empty, the current value of the free-running system time is stored and a valid flag rises. The latch then stays frozen. Further events in that direction are dropped, and a sticky missed flag records that one was lost. The latch reopens only when software reads the upper half of the held value.

Software reads the stored value as two 32-bit words, lower half first. Reading the lower half has no side effect. Reading the upper half releases the lock. On receive, a filter decides which packets are eligible. The filter uses an enable bit, a mode that selects either layer-4 version-1 messages of one configured type or all version-2 event messages, a UDP port compare, and an ethertype entry for version-2 packets carried directly over Ethernet. The packet parser supplies the packet fields alongside the receive strobe.

Top module: `pkt_tstamp_latch`

## Requirements
- R1: After reset every register reads zero. This covers enables, valid and missed flags, held values, filter settings and the ethertype entry.
- R2: A qualified event that arrives while its latch is empty stores `sys_time` as sampled at that clock edge. It also sets the valid flag, which is bit 1 of the control word at address 0 (transmit) or address 3 (receive).
- R3: While the valid flag is set, later events in that direction leave the held value unchanged.
- R4: A read strobe at address 2 (transmit) or address 5 (receive) returns bits 63:32 of the held value and clears the valid flag. The next qualified event is then captured.
- R5: A read at address 1 (transmit) or address 4 (receive) returns bits 31:0 of the held value and leaves the valid flag set.
- R6: When the enable bit (control bit 0) of a direction is clear, events in that direction capture nothing and set no flag.
- R7: An event that arrives while the latch is valid is dropped and sets the sticky missed flag (control bit 2). This includes an event in the same cycle as the releasing high-word read. Writing a control word with bit 2 set clears the missed flag, unless a new miss arrives in that same cycle.
- R8: Receive mode 1 (control bits 5:4 = 01) stamps only packets that meet all of these conditions: not layer-2, version 1, UDP port equal to the filter word bits 31:16, and message type equal to the filter word bits 3:0. The filter word is at address 6.
- R9: Receive mode 2 (control bits 5:4 = 10) stamps version-2 packets with a message type below 4. Each such packet must be either a layer-4 packet whose port matches, or a layer-2 packet whose ethertype equals bits 15:0 of the entry at address 7 while that entry has both bit 31 (enable) and bit 30 (stamp) set. Modes 00 and 11 stamp nothing.
- R10: The filter word and the ethertype entry read back the fields written into them. Writes to the stamp words are ignored.
- R11: The transmit and receive latches act independently when events and reads hit both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_time | input | 64 | Free-running system time |
| tx_evt | input | 1 | Transmit event packet at stamping point |
| rx_evt | input | 1 | Receive packet at stamping point |
| rx_is_l2 | input | 1 | Receive packet carried directly over Ethernet |
| rx_ver | input | 4 | Receive packet protocol version |
| rx_msg_type | input | 4 | Receive packet message type |
| rx_udp_port | input | 16 | Receive packet UDP destination port |
| rx_etype | input | 16 | Receive packet ethertype |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (side effects only) |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr`, combinational |

## Verification
The assertions assume that each event strobe lasts one cycle per packet. They also assume that the receive fields are meaningful whenever `rx_evt` is high, and that `sys_time` may take any value in any cycle. The stimulus drives single-cycle strobes. It draws packet fields from small sets that hit and miss each filter term, namely versions 1 to 3, message types around the event limit, port 319 and a neighbour, and two ethertypes. Reads and writes overlap freely with events, including the release-and-event collision. The bench compares the complete register view after every cycle against a model built from the requirements.

// File: rtl/tstamp_pkg.sv
`timescale 1ns/1ps
package tstamp_pkg;
  localparam int ADDR_W = 3;
  localparam int NUM_CH = 2;
  localparam int CH_TX  = 0;
  localparam int CH_RX  = 1;

  // control word bit positions
  localparam int CTL_EN_BIT    = 0;
  localparam int CTL_VALID_BIT = 1;
  localparam int CTL_MISS_BIT  = 2;
  localparam int CTL_MODE_LSB  = 4;
  // receive filter word
  localparam int FLT_PORT_LSB  = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_TX_CTRL = 3'd0,
    A_TX_LO   = 3'd1,
    A_TX_HI   = 3'd2,
    A_RX_CTRL = 3'd3,
    A_RX_LO   = 3'd4,
    A_RX_HI   = 3'd5,
    A_RX_FLT  = 3'd6,
    A_ETYPE   = 3'd7
  } csr_addr_e;

  typedef enum logic [1:0] {
    RXM_NONE  = 2'b00,
    RXM_V1_L4 = 2'b01,
    RXM_V2_EV = 2'b10,
    RXM_RSVD  = 2'b11
  } rx_mode_e;
endpackage

// File: rtl/ts_rx_filter.sv
`timescale 1ns/1ps
module ts_rx_filter
  import tstamp_pkg::*;
#(
  parameter int VER_W   = 4,
  parameter int MSG_W   = 4,
  parameter int PORT_W  = 16,
  parameter int ETYPE_W = 16,
  parameter int EVT_LIMIT = 4
) (
  input  logic               en,
  input  rx_mode_e           mode,
  input  logic [MSG_W-1:0]   msg_match,
  input  logic [PORT_W-1:0]  port_match,
  input  logic               et_en,
  input  logic               et_ts,
  input  logic [ETYPE_W-1:0] et_val,
  input  logic               pkt_is_l2,
  input  logic [VER_W-1:0]   pkt_ver,
  input  logic [MSG_W-1:0]   pkt_msg,
  input  logic [PORT_W-1:0]  pkt_port,
  input  logic [ETYPE_W-1:0] pkt_etype,
  output logic               hit
);
  localparam logic [VER_W-1:0] VER1    = VER_W'(1);
  localparam logic [VER_W-1:0] VER2    = VER_W'(2);
  localparam logic [MSG_W-1:0] MSG_LIM = MSG_W'(EVT_LIMIT);

  logic port_ok, l2_ok, v1_hit, v2_hit;

  always_comb begin
    port_ok = (pkt_port == port_match);
    l2_ok   = et_en && et_ts && (pkt_etype == et_val);
    v1_hit  = !pkt_is_l2 && (pkt_ver == VER1) && port_ok && (pkt_msg == msg_match);
    v2_hit  = (pkt_ver == VER2) && (pkt_msg < MSG_LIM) &&
              ((!pkt_is_l2 && port_ok) || (pkt_is_l2 && l2_ok));
    hit = 1'b0;
    if (en) begin
      case (mode)
        RXM_V1_L4: hit = v1_hit;
        RXM_V2_EV: hit = v2_hit;
        default:   hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ts_capture_latch.sv
`timescale 1ns/1ps
module ts_capture_latch #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [TIME_W-1:0] sys_time,
  input  logic              unlock,
  input  logic              miss_clr,
  output logic              valid,
  output logic              missed,
  output logic [TIME_W-1:0] stamp
);
  logic              valid_q, valid_d;
  logic              missed_q, missed_d;
  logic [TIME_W-1:0] stamp_q;
  logic              load;

  always_comb begin
    valid_d  = valid_q;
    missed_d = missed_q;
    load     = 1'b0;
    if (miss_clr) missed_d = 1'b0;
    if (evt) begin
      if (valid_q) missed_d = 1'b1;
      else begin
        valid_d = 1'b1;
        load    = 1'b1;
      end
    end
    if (unlock && valid_q) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      missed_q <= 1'b0;
    end else begin
      valid_q  <= valid_d;
      missed_q <= missed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stamp_q <= '0;
    else if (load) stamp_q <= sys_time;
  end

  assign valid  = valid_q;
  assign missed = missed_q;
  assign stamp  = stamp_q;

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !valid_q) |=> (valid_q && stamp_q == $past(sys_time)));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> $stable(stamp_q));
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && valid_q) |=> !valid_q);
  p_missed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && valid_q) |=> missed_q);
endmodule

// File: rtl/ts_csr.sv
`timescale 1ns/1ps
module ts_csr
  import tstamp_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int MSG_W   = 4,
  parameter int PORT_W  = 16,
  parameter int ETYPE_W = 16,
  localparam int TIME_W = 2 * REG_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic                           rd,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [REG_W-1:0]               wdata,
  output logic [REG_W-1:0]               rdata,
  input  logic [NUM_CH-1:0]              lat_valid,
  input  logic [NUM_CH-1:0]              lat_missed,
  input  logic [NUM_CH-1:0][TIME_W-1:0]  lat_stamp,
  output logic [NUM_CH-1:0]              en,
  output rx_mode_e                       mode,
  output logic [MSG_W-1:0]               msg_match,
  output logic [PORT_W-1:0]              port_match,
  output logic                           et_en,
  output logic                           et_ts,
  output logic [ETYPE_W-1:0]             et_val,
  output logic [NUM_CH-1:0]              unlock,
  output logic [NUM_CH-1:0]              miss_clr
);
  localparam int ET_EN_BIT = REG_W - 1;
  localparam int ET_TS_BIT = REG_W - 2;

  csr_addr_e            a;
  logic [NUM_CH-1:0]    en_q, en_d;
  rx_mode_e             mode_q, mode_d;
  logic [MSG_W-1:0]     msg_q, msg_d;
  logic [PORT_W-1:0]    port_q, port_d;
  logic                 eten_q, eten_d, etts_q, etts_d;
  logic [ETYPE_W-1:0]   etv_q, etv_d;
  logic                 unused_wdata;

  assign a            = csr_addr_e'(addr);
  assign unused_wdata = ^wdata;

  // next state and side-effect strobes
  always_comb begin
    en_d     = en_q;
    mode_d   = mode_q;
    msg_d    = msg_q;
    port_d   = port_q;
    eten_d   = eten_q;
    etts_d   = etts_q;
    etv_d    = etv_q;
    miss_clr = '0;
    unlock   = '0;
    if (wr) begin
      case (a)
        A_TX_CTRL: begin
          en_d[CH_TX]       = wdata[CTL_EN_BIT];
          miss_clr[CH_TX]   = wdata[CTL_MISS_BIT];
        end
        A_RX_CTRL: begin
          en_d[CH_RX]       = wdata[CTL_EN_BIT];
          mode_d            = rx_mode_e'(wdata[CTL_MODE_LSB +: 2]);
          miss_clr[CH_RX]   = wdata[CTL_MISS_BIT];
        end
        A_RX_FLT: begin
          msg_d  = wdata[MSG_W-1:0];
          port_d = wdata[FLT_PORT_LSB +: PORT_W];
        end
        A_ETYPE: begin
          eten_d = wdata[ET_EN_BIT];
          etts_d = wdata[ET_TS_BIT];
          etv_d  = wdata[ETYPE_W-1:0];
        end
        default: ;
      endcase
    end
    if (rd) begin
      if (a == A_TX_HI) unlock[CH_TX] = 1'b1;
      if (a == A_RX_HI) unlock[CH_RX] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= RXM_NONE;
      msg_q  <= '0;
      port_q <= '0;
      eten_q <= 1'b0;
      etts_q <= 1'b0;
      etv_q  <= '0;
    end else if (wr) begin
      en_q   <= en_d;
      mode_q <= mode_d;
      msg_q  <= msg_d;
      port_q <= port_d;
      eten_q <= eten_d;
      etts_q <= etts_d;
      etv_q  <= etv_d;
    end
  end

  // read view
  always_comb begin
    rdata = '0;
    case (a)
      A_TX_CTRL, A_RX_CTRL: begin
        rdata[CTL_EN_BIT]    = (a == A_TX_CTRL) ? en_q[CH_TX]       : en_q[CH_RX];
        rdata[CTL_VALID_BIT] = (a == A_TX_CTRL) ? lat_valid[CH_TX]  : lat_valid[CH_RX];
        rdata[CTL_MISS_BIT]  = (a == A_TX_CTRL) ? lat_missed[CH_TX] : lat_missed[CH_RX];
        if (a == A_RX_CTRL) rdata[CTL_MODE_LSB +: 2] = mode_q;
      end
      A_TX_LO: rdata = lat_stamp[CH_TX][REG_W-1:0];
      A_TX_HI: rdata = lat_stamp[CH_TX][TIME_W-1:REG_W];
      A_RX_LO: rdata = lat_stamp[CH_RX][REG_W-1:0];
      A_RX_HI: rdata = lat_stamp[CH_RX][TIME_W-1:REG_W];
      A_RX_FLT: begin
        rdata[MSG_W-1:0]               = msg_q;
        rdata[FLT_PORT_LSB +: PORT_W]  = port_q;
      end
      A_ETYPE: begin
        rdata[ET_EN_BIT]     = eten_q;
        rdata[ET_TS_BIT]     = etts_q;
        rdata[ETYPE_W-1:0]   = etv_q;
      end
      default: rdata = '0;
    endcase
  end

  assign en         = en_q;
  assign mode       = mode_q;
  assign msg_match  = msg_q;
  assign port_match = port_q;
  assign et_en      = eten_q;
  assign et_ts      = etts_q;
  assign et_val     = etv_q;

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(port_q) && $stable(msg_q) && $stable(etv_q)));
endmodule

// File: rtl/pkt_tstamp_latch.sv
`timescale 1ns/1ps
module pkt_tstamp_latch
  import tstamp_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int VER_W   = 4,
  parameter int MSG_W   = 4,
  parameter int PORT_W  = 16,
  parameter int ETYPE_W = 16,
  localparam int TIME_W = 2 * REG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIME_W-1:0]  sys_time,
  input  logic               tx_evt,
  input  logic               rx_evt,
  input  logic               rx_is_l2,
  input  logic [VER_W-1:0]   rx_ver,
  input  logic [MSG_W-1:0]   rx_msg_type,
  input  logic [PORT_W-1:0]  rx_udp_port,
  input  logic [ETYPE_W-1:0] rx_etype,
  input  logic               cfg_wr,
  input  logic               cfg_rd,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata
);
  logic [NUM_CH-1:0]             en, unlock, miss_clr, ch_evt;
  logic [NUM_CH-1:0]             lat_valid, lat_missed;
  logic [NUM_CH-1:0][TIME_W-1:0] lat_stamp;
  rx_mode_e                      mode;
  logic [MSG_W-1:0]              msg_match;
  logic [PORT_W-1:0]             port_match;
  logic                          et_en, et_ts;
  logic [ETYPE_W-1:0]            et_val;
  logic                          rx_hit;

  ts_csr #(
    .REG_W(REG_W), .MSG_W(MSG_W), .PORT_W(PORT_W), .ETYPE_W(ETYPE_W)
  ) u_csr (
    .clk(clk), .rst_n(rst_n),
    .wr(cfg_wr), .rd(cfg_rd), .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .lat_valid(lat_valid), .lat_missed(lat_missed), .lat_stamp(lat_stamp),
    .en(en), .mode(mode), .msg_match(msg_match), .port_match(port_match),
    .et_en(et_en), .et_ts(et_ts), .et_val(et_val),
    .unlock(unlock), .miss_clr(miss_clr)
  );

  ts_rx_filter #(
    .VER_W(VER_W), .MSG_W(MSG_W), .PORT_W(PORT_W), .ETYPE_W(ETYPE_W)
  ) u_filter (
    .en(en[CH_RX]), .mode(mode), .msg_match(msg_match), .port_match(port_match),
    .et_en(et_en), .et_ts(et_ts), .et_val(et_val),
    .pkt_is_l2(rx_is_l2), .pkt_ver(rx_ver), .pkt_msg(rx_msg_type),
    .pkt_port(rx_udp_port), .pkt_etype(rx_etype), .hit(rx_hit)
  );

  assign ch_evt[CH_TX] = tx_evt && en[CH_TX];
  assign ch_evt[CH_RX] = rx_evt && rx_hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lat
    ts_capture_latch #(.TIME_W(TIME_W)) u_lat (
      .clk(clk), .rst_n(rst_n),
      .evt(ch_evt[c]), .sys_time(sys_time),
      .unlock(unlock[c]), .miss_clr(miss_clr[c]),
      .valid(lat_valid[c]), .missed(lat_missed[c]), .stamp(lat_stamp[c])
    );
  end

  p_rx_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en[CH_RX] |-> !ch_evt[CH_RX]);
  p_lo_read_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_addr == A_TX_LO && lat_valid[CH_TX]) |=> lat_valid[CH_TX]);
  p_rx_unlock_tx_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock[CH_RX] && !unlock[CH_TX] && lat_valid[CH_TX]) |=> lat_valid[CH_TX]);
endmodule

// File: tb/pkt_tstamp_latch_bench.sv
`timescale 1ns/1ps
module pkt_tstamp_latch_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] sys_time;
  logic        tx_evt, rx_evt, rx_is_l2;
  logic [3:0]  rx_ver, rx_msg_type;
  logic [15:0] rx_udp_port, rx_etype;
  logic        cfg_wr, cfg_rd;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  // model state derived from the requirements
  bit          m_en [2];
  bit          m_valid [2];
  bit          m_miss [2];
  logic [63:0] m_stamp [2];
  logic [1:0]  m_mode;
  logic [3:0]  m_msg;
  logic [15:0] m_port;
  bit          m_eten, m_etts;
  logic [15:0] m_etval;

  always #2 clk = ~clk;

  pkt_tstamp_latch u_pkt_tstamp_latch (
    .clk(clk), .rst_n(rst_n), .sys_time(sys_time),
    .tx_evt(tx_evt), .rx_evt(rx_evt), .rx_is_l2(rx_is_l2), .rx_ver(rx_ver),
    .rx_msg_type(rx_msg_type), .rx_udp_port(rx_udp_port), .rx_etype(rx_etype),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  function automatic bit exp_filter();
    if (!m_en[1]) return 1'b0;
    if (m_mode == 2'b01)
      return !rx_is_l2 && rx_ver == 4'd1 && rx_udp_port == m_port && rx_msg_type == m_msg;
    if (m_mode == 2'b10)
      return rx_ver == 4'd2 && rx_msg_type < 4'd4 &&
             ((!rx_is_l2 && rx_udp_port == m_port) ||
              (rx_is_l2 && m_eten && m_etts && rx_etype == m_etval));
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_read(int a);
    logic [31:0] v = '0;
    case (a)
      0, 3: begin
        v[0] = m_en[a/3]; v[1] = m_valid[a/3]; v[2] = m_miss[a/3];
        if (a == 3) v[5:4] = m_mode;
      end
      1: v = m_stamp[0][31:0];
      2: v = m_stamp[0][63:32];
      4: v = m_stamp[1][31:0];
      5: v = m_stamp[1][63:32];
      6: begin v[3:0] = m_msg; v[31:16] = m_port; end
      default: begin v[31] = m_eten; v[30] = m_etts; v[15:0] = m_etval; end
    endcase
    return v;
  endfunction

  task automatic model_step();
    bit hit [2];
    bit unl [2];
    bit clr [2];
    hit[0] = tx_evt && m_en[0];
    hit[1] = rx_evt && exp_filter();
    unl[0] = cfg_rd && cfg_addr == 3'd2;
    unl[1] = cfg_rd && cfg_addr == 3'd5;
    clr[0] = cfg_wr && cfg_addr == 3'd0 && cfg_wdata[2];
    clr[1] = cfg_wr && cfg_addr == 3'd3 && cfg_wdata[2];
    for (int c = 0; c < 2; c++) begin
      bit nv = m_valid[c];
      if (clr[c]) m_miss[c] = 1'b0;
      if (hit[c]) begin
        if (m_valid[c]) m_miss[c] = 1'b1;
        else begin nv = 1'b1; m_stamp[c] = sys_time; end
      end
      if (unl[c] && m_valid[c]) nv = 1'b0;
      m_valid[c] = nv;
    end
    if (cfg_wr) begin
      case (cfg_addr)
        3'd0: m_en[0] = cfg_wdata[0];
        3'd3: begin m_en[1] = cfg_wdata[0]; m_mode = cfg_wdata[5:4]; end
        3'd6: begin m_msg = cfg_wdata[3:0]; m_port = cfg_wdata[31:16]; end
        3'd7: begin m_eten = cfg_wdata[31]; m_etts = cfg_wdata[30]; m_etval = cfg_wdata[15:0]; end
        default: ;
      endcase
    end
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input int a);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s addr %0d: actual %h expected %h", tag, a, act, exp);
    end
  endtask

  // compares the whole register view; no strobes are active meanwhile
  task automatic check_all(input string ovr);
    tx_evt = 0; rx_evt = 0; cfg_wr = 0; cfg_rd = 0;
    for (int a = 0; a < 8; a++) begin
      string tag;
      cfg_addr = 3'(a);
      #0.4;
      case (a)
        0, 3: tag = "R7";
        1, 4: tag = "R5";
        2, 5: tag = "R4";
        default: tag = "R10";
      endcase
      if (ovr != "") tag = ovr;
      chk(cfg_rdata, exp_read(a), tag, a);
    end
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    tx_evt = 0; rx_evt = 0; cfg_wr = 0; cfg_rd = 0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    cfg_wr = 1; cfg_addr = 3'(a); cfg_wdata = d; step();
  endtask

  task automatic rd(input int a);
    cfg_rd = 1; cfg_addr = 3'(a); step();
  endtask

  task automatic pkt(input bit l2, input int ver, input int msg, input int port, input int et);
    rx_evt = 1; rx_is_l2 = l2; rx_ver = 4'(ver); rx_msg_type = 4'(msg);
    rx_udp_port = 16'(port); rx_etype = 16'(et);
    sys_time = {$urandom, $urandom};
    step();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog R1: actual hung run, expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h1588));
    rst_n = 0; sys_time = '0; tx_evt = 0; rx_evt = 0; rx_is_l2 = 0;
    rx_ver = '0; rx_msg_type = '0; rx_udp_port = '0; rx_etype = '0;
    cfg_wr = 0; cfg_rd = 0; cfg_addr = '0; cfg_wdata = '0;
    for (int c = 0; c < 2; c++) begin
      m_en[c] = 0; m_valid[c] = 0; m_miss[c] = 0; m_stamp[c] = '0;
    end
    m_mode = '0; m_msg = '0; m_port = '0; m_eten = 0; m_etts = 0; m_etval = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");
    @(negedge clk);

    // transmit capture, hold, low read, high release
    wr(0, 32'h1);
    sys_time = 64'h0123_4567_89AB_CDEF; tx_evt = 1; step(); check_all("R2"); @(negedge clk);
    sys_time = 64'hFFFF_0000_FFFF_0000; tx_evt = 1; step(); check_all("R3"); @(negedge clk);
    rd(1); check_all("R5"); @(negedge clk);
    rd(2); check_all("R4"); @(negedge clk);
    sys_time = 64'h0000_0001_0000_0002; tx_evt = 1; step(); check_all("R4"); @(negedge clk);
    wr(0, 32'h5); check_all("R7"); @(negedge clk);
    // release and event in the same cycle
    sys_time = 64'hDEAD_BEEF_0000_1111; tx_evt = 1; cfg_rd = 1; cfg_addr = 3'd2; step();
    check_all("R7"); @(negedge clk);
    // disabled directions
    wr(0, 32'h4); sys_time = 64'h55; tx_evt = 1; step(); check_all("R6"); @(negedge clk);
    wr(3, 32'h20); wr(6, {16'd319, 16'h0});
    pkt(0, 2, 0, 319, 0); check_all("R6"); @(negedge clk);

    // receive mode 1
    wr(3, 32'h11);
    pkt(0, 1, 0, 319, 0);      check_all("R8"); @(negedge clk);
    rd(5);
    pkt(0, 1, 0, 320, 0);      check_all("R8"); @(negedge clk);
    pkt(0, 1, 1, 319, 0);      check_all("R8"); @(negedge clk);
    pkt(1, 1, 0, 319, 16'h88F7); check_all("R8"); @(negedge clk);
    pkt(0, 2, 0, 319, 0);      check_all("R8"); @(negedge clk);

    // receive mode 2
    wr(3, 32'h21);
    pkt(0, 2, 3, 319, 0);      check_all("R9"); @(negedge clk);
    rd(5);
    pkt(0, 2, 8, 319, 0);      check_all("R9"); @(negedge clk);
    pkt(1, 2, 0, 0, 16'h88F7); check_all("R9"); @(negedge clk);
    wr(7, 32'h4000_88F7);
    pkt(1, 2, 0, 0, 16'h88F7); check_all("R9"); @(negedge clk);
    wr(7, 32'hC000_88F7);
    pkt(1, 2, 1, 0, 16'h0800); check_all("R9"); @(negedge clk);
    pkt(1, 2, 1, 0, 16'h88F7); check_all("R9"); @(negedge clk);
    rd(5);
    pkt(0, 1, 0, 319, 0);      check_all("R9"); @(negedge clk);
    wr(3, 32'h31);
    pkt(0, 2, 0, 319, 0);      check_all("R9"); @(negedge clk);
    wr(1, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF); check_all("R10"); @(negedge clk);

    // both directions at once
    wr(0, 32'h1); wr(3, 32'h21); rd(2); rd(5);
    tx_evt = 1; rx_evt = 1; rx_is_l2 = 0; rx_ver = 4'd2; rx_msg_type = 4'd1;
    rx_udp_port = 16'd319; sys_time = 64'hAAAA_5555_1234_0000;
    step(); check_all("R11"); @(negedge clk);
    tx_evt = 1; cfg_rd = 1; cfg_addr = 3'd5; step(); check_all("R11"); @(negedge clk);

    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      sys_time    = {$urandom, $urandom};
      tx_evt      = ($urandom % 3) == 0;
      rx_evt      = ($urandom % 2) == 0;
      rx_is_l2    = $urandom % 2;
      rx_ver      = 4'(1 + $urandom % 3);
      rx_msg_type = 4'($urandom % 6);
      rx_udp_port = ($urandom % 4 == 0) ? 16'd320 : 16'd319;
      rx_etype    = ($urandom % 4 == 0) ? 16'h0800 : 16'h88F7;
      if ($urandom % 3 == 0) begin
        cfg_rd = 1; cfg_addr = 3'($urandom % 8);
      end
      if ($urandom % 8 == 0) begin
        int sel = $urandom % 4;
        cfg_wr = 1;
        case (sel)
          0: begin cfg_addr = 3'd0; cfg_wdata = {29'd0, 1'($urandom), 1'b0, 1'($urandom % 5 != 0)}; end
          1: begin cfg_addr = 3'd3; cfg_wdata = {26'd0, 2'($urandom), 1'b0, 1'($urandom), 1'b0, 1'($urandom % 5 != 0)}; end
          2: begin cfg_addr = 3'd6; cfg_wdata = {(($urandom % 4 == 0) ? 16'd320 : 16'd319), 12'd0, 4'($urandom % 4)}; end
          default: begin cfg_addr = 3'd7; cfg_wdata = {1'($urandom), 1'($urandom), 14'd0, 16'h88F7}; end
        endcase
        if (cfg_rd && cfg_addr != 3'($urandom % 8)) cfg_rd = 0;
      end
      step();
      check_all("");
      @(negedge clk);
    end
    finish_run();
  end
endmodule